// File: doc/BRIEF.md
# Stereo Source Selector and Averager

This block sits in an audio path just before the per-channel volume stage. Each cycle that a stereo sample pair is presented, it builds two output channels, A and B, from the signed left and right inputs. A 5-bit mixing code picks, for each output, silence, the left sample, the right sample, or the mean of the two. Two separate mute inputs can silence either output whatever the code says.

The gain multiply is done downstream. This block only tells the volume stage whether the A and B gains act as one shared factor. That shared setting comes from the top bit of the mixing code, and it travels with the samples. The mean is taken on a sign-extended sum, so it can never wrap. It rounds toward negative infinity. Results are registered one cycle after the input strobe, and the strobe is forwarded with them.

Top module: `atapi_mix`

## Requirements
- R1: While reset is held, and after it is released until the first strobed sample, `outValid`, `outGainTied`, `outA` and `outB` are all zero.
- R2: `outValid` is high in exactly the cycle after a cycle with `inValid` high. The samples and the gain flag computed from that cycle's inputs appear together with it.
- R3: Output A takes its source from `mixCode[3:2]`: 00 gives zero, 01 gives the right input, 10 gives the left input, and 11 gives the average of both. Code 01001 therefore gives A = left and B = right.
- R4: Output B takes its source from `mixCode[1:0]`, using the same encoding as output A.
- R5: The average is floor((left + right) / 2), taken over 25 bits. Two full-scale positive inputs give 0x7FFFFF, and two full-scale negative inputs give 0x800000.
- R6: With `muteA` high, `outA` is zero for that sample whatever the code is. With `muteB` high, `outB` is zero in the same way. Neither mute affects the other output.
- R7: `outGainTied` carries `mixCode[4]` for each strobed sample. That bit does not change which source either output takes.
- R8: In a cycle with `inValid` low, `outA`, `outB` and `outGainTied` keep their values, whatever the other inputs do.
- R9: When `mixCode[4]` is set and both selections are 11 with neither mute active, `outA` and `outB` carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe marking a new sample pair |
| inLeft | input | 24 | Left sample, two's complement |
| inRight | input | 24 | Right sample, two's complement |
| mixCode | input | 5 | Bit 4 ties the gains; bits 3:2 select A; bits 1:0 select B |
| muteA | input | 1 | Forces output A to zero |
| muteB | input | 1 | Forces output B to zero |
| outValid | output | 1 | Strobe for the registered outputs |
| outA | output | 24 | Output channel A sample |
| outB | output | 24 | Output channel B sample |
| outGainTied | output | 1 | Tells the volume stage to apply one shared gain to both outputs |

## Verification
A decode error in the control half would put the wrong source, or a stray zero, on an output channel at the first strobed sample after the faulty code is applied. Because every output register reloads on each strobe, the error shows one cycle later and clears once a correct sample follows. A fault in the adder or shift shows only on the average selection, and only for some values. For that reason the bench uses odd sums with negative values and both full-scale extremes, where a truncating or wrapping mean differs from the floor. A load-enable fault shows as outputs that change while the strobe is low.

// File: rtl/atapi_mix_pkg.sv
package atapi_mix_pkg;

  localparam int SEL_W = 2;

  // Per-output source selection; the encoding matches the code fields
  typedef enum logic [SEL_W-1:0] {
    SRC_ZERO  = 2'b00,
    SRC_RIGHT = 2'b01,
    SRC_LEFT  = 2'b10,
    SRC_MEAN  = 2'b11
  } srcSel_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic    load;
    logic    tied;
    srcSel_e selA;
    srcSel_e selB;
  } mixCtrl_t;

endpackage

// File: rtl/atapi_mix_ctrl.sv
module atapi_mix_ctrl
  import atapi_mix_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              inValid,
  input  logic [CODE_W-1:0] mixCode,
  input  logic              muteA,
  input  logic              muteB,
  output mixCtrl_t          ctrl
);

  localparam int TIE_BIT = CODE_W - 1;
  localparam int A_LSB   = 2 * SEL_W - 2;
  localparam int B_LSB   = 0;

  srcSel_e rawA;
  srcSel_e rawB;

  always_comb begin
    rawA = srcSel_e'(mixCode[A_LSB +: SEL_W]);
    rawB = srcSel_e'(mixCode[B_LSB +: SEL_W]);
    ctrl.load = inValid;
    ctrl.tied = mixCode[TIE_BIT];
    // A mute overrides whatever source the code selects
    ctrl.selA = muteA ? SRC_ZERO : rawA;
    ctrl.selB = muteB ? SRC_ZERO : rawB;
  end

endmodule

// File: rtl/atapi_mix_datapath.sv
module atapi_mix_datapath
  import atapi_mix_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NUM_OUT  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  mixCtrl_t            ctrl,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                outValid,
  output logic                outTied,
  output logic [SAMPLE_W-1:0] outCh [NUM_OUT]
);

  localparam int SUM_W = SAMPLE_W + 1;

  logic [SUM_W-1:0]    sumFull;
  logic [SAMPLE_W-1:0] meanVal;
  srcSel_e             chanSel [NUM_OUT];

  // Sign-extended sum cannot wrap; dropping bit 0 is a floor halving
  always_comb begin
    sumFull = {inLeft[SAMPLE_W-1], inLeft} + {inRight[SAMPLE_W-1], inRight};
    meanVal = sumFull[SUM_W-1:1];
  end

  assign chanSel[0] = ctrl.selA;
  assign chanSel[1] = ctrl.selB;

  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] nextVal;
    logic [SAMPLE_W-1:0] holdVal;

    always_comb begin
      unique case (chanSel[ch])
        SRC_RIGHT: nextVal = inRight;
        SRC_LEFT:  nextVal = inLeft;
        SRC_MEAN:  nextVal = meanVal;
        default:   nextVal = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN)          holdVal <= '0;
      else if (ctrl.load) holdVal <= nextVal;
    end

    assign outCh[ch] = holdVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outTied  <= 1'b0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) outTied <= ctrl.tied;
    end
  end

endmodule

// File: rtl/atapi_mix.sv
module atapi_mix
  import atapi_mix_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  input  logic [CODE_W-1:0]   mixCode,
  input  logic                muteA,
  input  logic                muteB,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outA,
  output logic [SAMPLE_W-1:0] outB,
  output logic                outGainTied
);

  localparam int NUM_OUT = 2;

  mixCtrl_t            ctrl;
  logic [SAMPLE_W-1:0] outCh [NUM_OUT];

  atapi_mix_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .inValid (inValid),
    .mixCode (mixCode),
    .muteA   (muteA),
    .muteB   (muteB),
    .ctrl    (ctrl)
  );

  atapi_mix_datapath #(.SAMPLE_W(SAMPLE_W), .NUM_OUT(NUM_OUT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .inLeft   (inLeft),
    .inRight  (inRight),
    .outValid (outValid),
    .outTied  (outGainTied),
    .outCh    (outCh)
  );

  assign outA = outCh[0];
  assign outB = outCh[1];

endmodule

// File: rtl/atapi_mix_checker.sv
module atapi_mix_checker #(
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [SAMPLE_W-1:0] inLeft,
  input logic [SAMPLE_W-1:0] inRight,
  input logic [CODE_W-1:0]   mixCode,
  input logic                muteA,
  input logic                muteB,
  input logic                outValid,
  input logic [SAMPLE_W-1:0] outA,
  input logic [SAMPLE_W-1:0] outB,
  input logic                outGainTied
);

  // R2: the strobe is forwarded with one cycle of latency
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3: the left selection on A passes the left sample through unchanged
  a_r3_left_on_a: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !muteA && mixCode[3:2] == 2'b10) |=> outA == $past(inLeft));

  // R6: the mutes force zero
  a_r6_mute_a: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && muteA) |=> outA == '0);
  a_r6_mute_b: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && muteB) |=> outB == '0);

  // R7: the gain flag tracks code bit 4
  a_r7_tied_flag: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outGainTied == $past(mixCode[CODE_W-1]));

  // R8: no strobe, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outA) && $stable(outB) && $stable(outGainTied)));

  // R9: shared mean drives both outputs identically
  a_r9_shared_mean: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mixCode == 5'b11111 && !muteA && !muteB) |=> outA == outB);

endmodule

bind atapi_mix atapi_mix_checker #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inLeft      (inLeft),
  .inRight     (inRight),
  .mixCode     (mixCode),
  .muteA       (muteA),
  .muteB       (muteB),
  .outValid    (outValid),
  .outA        (outA),
  .outB        (outB),
  .outGainTied (outGainTied)
);

// File: tb/atapi_mix_bench.sv
`timescale 1ns/1ps
module atapi_mix_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [23:0] inLeft, inRight;
  logic [4:0]  mixCode;
  logic        muteA, muteB;
  logic        outValid;
  logic [23:0] outA, outB;
  logic        outGainTied;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  atapi_mix u_atapi_mix (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLeft(inLeft),
    .inRight(inRight), .mixCode(mixCode), .muteA(muteA), .muteB(muteB),
    .outValid(outValid), .outA(outA), .outB(outB), .outGainTied(outGainTied)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected source value from the encoding in R3/R4/R5/R6
  function automatic logic [23:0] pick(logic [1:0] s, logic m, logic [23:0] l, logic [23:0] r);
    integer sum;
    if (m) return 24'h0;
    case (s)
      2'b01: return r;
      2'b10: return l;
      2'b11: begin
        sum = $signed(l) + $signed(r);
        return 24'(sum >>> 1);
      end
      default: return 24'h0;
    endcase
  endfunction

  // Drive one strobed pair at a falling edge, sample at the next falling edge
  task automatic apply(string req, logic [23:0] l, logic [23:0] r,
                       logic [4:0] code, logic mA, logic mB);
    inLeft = l; inRight = r; mixCode = code; muteA = mA; muteB = mB;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R2 valid"}, 32'(outValid), 32'd1);
    check({req, " A"}, 32'(outA), 32'(pick(code[3:2], mA, l, r)));
    check({req, " B"}, 32'(outB), 32'(pick(code[1:0], mB, l, r)));
    check({req, " R7 tied"}, 32'(outGainTied), 32'(code[4]));
  endtask

  task automatic t_reset();
    rstN = 1'b0; inValid = 1'b0; inLeft = '0; inRight = '0;
    mixCode = 5'b01001; muteA = 1'b0; muteB = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid", 32'(outValid), 0);
    check("R1 A", 32'(outA), 0);
    check("R1 B", 32'(outB), 0);
    check("R1 tied", 32'(outGainTied), 0);
  endtask

  task automatic t_routes();
    apply("R3 R4 stereo", 24'h123456, 24'hFEDCBA, 5'b01001, 0, 0);
    apply("R3 R4 swap",   24'h123456, 24'hFEDCBA, 5'b00110, 0, 0);
    apply("R3 R4 zero",   24'h0A0A0A, 24'h050505, 5'b00000, 0, 0);
    apply("R3 R4 mixed",  24'h0A0A0A, 24'h050505, 5'b00010, 0, 0);
    apply("R3 R4 leftboth", 24'h777777, 24'h111111, 5'b01010, 0, 0);
  endtask

  task automatic t_average();
    apply("R5 neg odd",  24'hFFFFFF, 24'h000000, 5'b01111, 0, 0);
    check("R5 floor -1", 32'(outA), 32'h00FFFFFF);
    apply("R5 pos odd",  24'h000001, 24'h000000, 5'b01111, 0, 0);
    check("R5 floor 0",  32'(outB), 32'h0);
    apply("R5 mixed",    24'h000003, 24'hFFFFFA, 5'b01111, 0, 0);
    check("R5 floor -2", 32'(outA), 32'h00FFFFFE);
    apply("R5 max",      24'h7FFFFF, 24'h7FFFFF, 5'b01111, 0, 0);
    check("R5 max",      32'(outA), 32'h007FFFFF);
    apply("R5 min",      24'h800000, 24'h800000, 5'b01111, 0, 0);
    check("R5 min",      32'(outB), 32'h00800000);
  endtask

  task automatic t_mutes();
    apply("R6 muteA",  24'h222222, 24'h333333, 5'b01001, 1, 0);
    apply("R6 muteB",  24'h222222, 24'h333333, 5'b01001, 0, 1);
    apply("R6 both",   24'h222222, 24'h333333, 5'b11111, 1, 1);
  endtask

  task automatic t_tied();
    apply("R9 shared", 24'h000005, 24'h000008, 5'b11111, 0, 0);
    check("R9 equal", 32'(outA), 32'(outB));
    check("R9 value", 32'(outA), 32'h6);
    apply("R7 stereo tied", 24'h444444, 24'h555555, 5'b11001, 0, 0);
  endtask

  task automatic t_hold();
    logic [23:0] a0, b0;
    apply("R8 prime", 24'h0ABCDE, 24'h012345, 5'b11001, 0, 0);
    a0 = outA; b0 = outB;
    inLeft = 24'h999999; inRight = 24'h888888; mixCode = 5'b00000;
    muteA = 1; muteB = 1;
    repeat (2) @(negedge clk);
    check("R2 dropped", 32'(outValid), 0);
    check("R8 A", 32'(outA), 32'(a0));
    check("R8 B", 32'(outB), 32'(b0));
    check("R8 tied", 32'(outGainTied), 1);
  endtask

  initial begin
    t_reset();
    t_routes();
    t_average();
    t_mutes();
    t_tied();
    t_hold();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule